// File: doc/BRIEF.md
# Periodic Interval Timer

The block produces a steady periodic time base from the input clock. A fixed divide-by-16 prescaler advances a 20-bit up-counter, and software programs the period through a small register bus. When the counter reaches the programmed limit it returns to zero. That return is called a wrap. Each wrap bumps a 12-bit tally of completed periods and raises a status flag. The flag also drives an interrupt line if that line is enabled.

Software can see the tally and the live counter in two places. The acknowledging view clears the tally and the flag on the same clock edge that delivers the read. The image view returns the same word and clears nothing. A driver can therefore learn how many periods passed since its last service, and it can also sample elapsed time freely without disturbing the interrupt.

Turning the timer off does not freeze the count in the middle of a period. The counter finishes its current period, wraps to zero and then holds there. Software can poll for a zero count to learn that the timer has fully stopped.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset every register reads as zero and `irq_o` is low.
- R2: While the timer runs, the counter advances once every 16 clock edges. The first step comes on the 16th edge after the edge that wrote the enable bit.
- R3: Mode bits 19:0 hold the period minus one, called the limit. The counter goes 0, 1, …, limit and then returns to 0. If the limit is lowered below the current count, the counter returns to 0 on its next step.
- R4: The mode register is at offset 0x0. Bit 24 is the run enable and bit 25 is the interrupt enable. A read returns the written limit and both bits, and all other bits read zero.
- R5: Every wrap raises the tally in bits 31:20 of the value and image words by one. The tally stops at 4095 instead of rolling over.
- R6: The status register is at offset 0x4. Its bit 0 is set by a wrap and stays set until the value register is read.
- R7: `irq_o` is high exactly when the status flag is set and the interrupt enable is set. With the interrupt enable clear, the flag still sets but `irq_o` stays low.
- R8: A read of the value register at offset 0x8 returns {tally, counter} as they stood before the edge. On that edge it clears the tally and the flag. If a wrap lands on the same edge, the tally becomes 1 and the flag stays set.
- R9: A read of the image register at offset 0xC returns the same word as a value read, and it changes no state.
- R10: When the run enable is cleared, the counter keeps stepping until it wraps. That wrap still counts in the tally and sets the flag. The counter then holds at zero.
- R11: Writes to offsets 0x4, 0x8 and 0xC have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A wrong prescaler phase or a wrong wrap point shows in the counter field of the image word within one period of sixteen edges, and every cycle of the sweep reads that word. A tally or flag that fails to clear, fails to set or fails to saturate shows in the next image or status read and on `irq_o` in the same cycle. The sweeps probe the coincident read-and-wrap edge, a lowered limit and the drain-to-zero after disable directly, because an error there stays hidden until the next wrap.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    // register slots, decoded from bus_addr[3:2]
    typedef enum logic [1:0] {
        SLOT_MODE  = 2'd0,
        SLOT_STAT  = 2'd1,
        SLOT_VALUE = 2'd2,
        SLOT_IMAGE = 2'd3
    } slot_e;

    localparam int unsigned RUN_BIT  = 24;
    localparam int unsigned IRQE_BIT = 25;
    localparam int unsigned FLAG_BIT = 0;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int unsigned DIV_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam logic [DIV_W-1:0] LAST = {DIV_W{1'b1}};

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            st_d.phase = st_q.phase + 1'b1;
        end else begin
            st_d.phase = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = run_i && (st_q.phase == LAST);

    // R2
    phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> st_q.phase == '0);
endmodule

// File: rtl/ivt_period_counter.sv
module ivt_period_counter #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] value_o,
    output logic             wrap_o,
    output logic             run_o
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } state_t;

    state_t st_d, st_q;

    assign run_o   = en_i || (st_q.value != '0);
    assign wrap_o  = tick_i && (st_q.value >= limit_i);
    assign value_o = st_q.value;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (st_q.value >= limit_i) begin
                st_d.value = '0;
            end else begin
                st_d.value = st_q.value + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && st_q.value == '0) |=> st_q.value == '0);
endmodule

// File: rtl/ivt_tally.sv
module ivt_tally #(
    parameter int unsigned TALLY_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wrap_i,
    input  logic               clr_i,
    output logic [TALLY_W-1:0] tally_o,
    output logic               flag_o
);
    localparam logic [TALLY_W-1:0] TOP = {TALLY_W{1'b1}};
    localparam logic [TALLY_W-1:0] ONE = {{(TALLY_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TALLY_W-1:0] tally;
        logic               flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.tally = wrap_i ? ONE : '0;
            st_d.flag  = wrap_i;
        end else if (wrap_i) begin
            if (st_q.tally != TOP) begin
                st_d.tally = st_q.tally + 1'b1;
            end
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tally_o = st_q.tally;
    assign flag_o  = st_q.flag;

    // R5
    tally_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.tally == TOP && !clr_i) |=> st_q.tally == TOP);
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_i |=> st_q.flag);
    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !wrap_i) |=> (st_q.tally == '0 && !st_q.flag));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int unsigned CNT_W   = 20,
    parameter int unsigned TALLY_W = 12,
    parameter int unsigned DIV_W   = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    import ivt_pkg::*;

    localparam int unsigned TALLY_LSB = DATA_W - TALLY_W;

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic             run;
        logic             irqe;
    } mode_t;

    mode_t mode_d, mode_q;

    slot_e             slot;
    logic              wr_mode;
    logic              ack;
    logic              tick;
    logic              run;
    logic              wrap;
    logic [CNT_W-1:0]  count;
    logic [TALLY_W-1:0] tally;
    logic              flag;
    logic [DATA_W-1:0] mode_word;
    logic [DATA_W-1:0] count_word;
    logic [DATA_W-1:0] stat_word;

    assign slot    = slot_e'(bus_addr[3:2]);
    assign wr_mode = bus_sel && bus_wr && (slot == SLOT_MODE);
    assign ack     = bus_sel && !bus_wr && (slot == SLOT_VALUE);

    always_comb begin
        mode_d = mode_q;
        if (wr_mode) begin
            mode_d.limit = bus_wdata[CNT_W-1:0];
            mode_d.run   = bus_wdata[RUN_BIT];
            mode_d.irqe  = bus_wdata[IRQE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    ivt_prescaler #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    ivt_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en_i    (mode_q.run),
        .tick_i  (tick),
        .limit_i (mode_q.limit),
        .value_o (count),
        .wrap_o  (wrap),
        .run_o   (run)
    );

    ivt_tally #(.TALLY_W(TALLY_W)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .wrap_i  (wrap),
        .clr_i   (ack),
        .tally_o (tally),
        .flag_o  (flag)
    );

    always_comb begin
        mode_word                  = '0;
        mode_word[CNT_W-1:0]       = mode_q.limit;
        mode_word[RUN_BIT]         = mode_q.run;
        mode_word[IRQE_BIT]        = mode_q.irqe;
        count_word                 = '0;
        count_word[CNT_W-1:0]      = count;
        count_word[TALLY_LSB +: TALLY_W] = tally;
        stat_word                  = '0;
        stat_word[FLAG_BIT]        = flag;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (slot)
                SLOT_MODE:  bus_rdata = mode_word;
                SLOT_STAT:  bus_rdata = stat_word;
                SLOT_VALUE: bus_rdata = count_word;
                SLOT_IMAGE: bus_rdata = count_word;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = flag && mode_q.irqe;

    // R2
    step_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack && !wr_mode) |=> irq_o);
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // independent bench model
    logic [19:0] m_lim = '0;
    logic        m_run = 1'b0;
    logic        m_ie  = 1'b0;
    logic [19:0] m_cnt = '0;
    logic [3:0]  m_div = '0;
    int          m_tally = 0;
    logic        m_flag = 1'b0;

    always #5 clk = ~clk;

    interval_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [31:0] expect_word(input logic [3:0] a);
        logic [31:0] w;
        w = '0;
        case (a[3:2])
            2'd0: begin w[19:0] = m_lim; w[24] = m_run; w[25] = m_ie; end
            2'd1: w[0] = m_flag;
            default: begin w[19:0] = m_cnt; w[31:20] = 12'(m_tally); end
        endcase
        return w;
    endfunction

    task automatic model_reset();
        m_lim = '0; m_run = 1'b0; m_ie = 1'b0; m_cnt = '0;
        m_div = '0; m_tally = 0; m_flag = 1'b0;
    endtask

    task automatic model_edge(input logic sel, input logic wr,
                              input logic [3:0] a, input logic [31:0] wd);
        logic running, tick, wrap, clr;
        running = m_run || (m_cnt != 0);
        tick    = running && (m_div == 4'hF);
        wrap    = tick && (m_cnt >= m_lim);
        m_div   = running ? m_div + 4'd1 : 4'd0;
        if (tick) m_cnt = wrap ? 20'd0 : m_cnt + 20'd1;
        clr = sel && !wr && (a[3:2] == 2'd2);
        if (clr) begin
            m_tally = wrap ? 1 : 0;
            m_flag  = wrap;
        end else if (wrap) begin
            if (m_tally < 4095) m_tally = m_tally + 1;
            m_flag = 1'b1;
        end
        if (sel && wr && a[3:2] == 2'd0) begin
            m_lim = wd[19:0]; m_run = wd[24]; m_ie = wd[25];
        end
    endtask

    // one bus cycle; reads are compared before the edge that acts on them
    task automatic cycle(input logic sel, input logic wr, input logic [3:0] a,
                         input logic [31:0] wd, input string tag);
        logic [31:0] exp_w;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        if (sel && !wr) begin
            exp_w = expect_word(a);
            vectors++;
            if (bus_rdata !== exp_w) begin
                errors++;
                $display("FAIL %s addr=%h rdata=%h expected=%h", tag, a, bus_rdata, exp_w);
            end
        end
        vectors++;
        if (irq_o !== (m_flag && m_ie)) begin
            errors++;
            $display("FAIL R7 (%s) irq=%b expected=%b", tag, irq_o, m_flag && m_ie);
        end
        @(posedge clk);
        model_edge(sel, wr, a, wd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] mode_val(input logic ie, input logic en,
                                             input logic [19:0] lim);
        logic [31:0] w;
        w = '0; w[19:0] = lim; w[24] = en; w[25] = ie;
        return w;
    endfunction

    initial begin
        #(10 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int lims[5];
        lims = '{0, 1, 2, 3, 6};
        do_reset();

        // R1: reset state of every register
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 4'(i * 4), '0, "R1");

        // R2 R3 R5 R9 R6 R8: sweep over several limits
        foreach (lims[j]) begin
            do_reset();
            cycle(1'b1, 1'b1, 4'h0, mode_val(1'b1, 1'b1, 20'(lims[j])), "R4");
            cycle(1'b1, 1'b0, 4'h0, '0, "R4");
            for (int k = 0; k < (lims[j] + 1) * 16 * 3 + 20; k++)
                cycle(1'b1, 1'b0, 4'hC, '0, "R2 R3 R5 R9");
            cycle(1'b1, 1'b0, 4'h4, '0, "R6");
            cycle(1'b1, 1'b0, 4'h8, '0, "R8");
            for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, 4'hC, '0, "R8 R9");
            // align a value read onto a wrap edge
            while (!(m_div == 4'hF && m_cnt >= m_lim))
                cycle(1'b1, 1'b0, 4'hC, '0, "R9");
            cycle(1'b1, 1'b0, 4'h8, '0, "R8 coincident");
            cycle(1'b1, 1'b0, 4'hC, '0, "R8 coincident");
            cycle(1'b1, 1'b0, 4'h4, '0, "R8 coincident");
        end

        // R7: interrupt enable clear, flag still sets
        do_reset();
        cycle(1'b1, 1'b1, 4'h0, mode_val(1'b0, 1'b1, 20'd1), "R7");
        for (int k = 0; k < 100; k++) cycle(1'b1, 1'b0, 4'h4, '0, "R7");
        cycle(1'b1, 1'b0, 4'hC, '0, "R7");

        // R10: disable mid-period, drain to zero and hold
        do_reset();
        cycle(1'b1, 1'b1, 4'h0, mode_val(1'b1, 1'b1, 20'd5), "R10");
        for (int k = 0; k < 130; k++) cycle(1'b1, 1'b0, 4'hC, '0, "R10");
        cycle(1'b1, 1'b1, 4'h0, '0, "R10");
        for (int k = 0; k < 250; k++) cycle(1'b1, 1'b0, 4'hC, '0, "R10");
        cycle(1'b1, 1'b0, 4'h4, '0, "R10");

        // R11: writes to other offsets ignored
        do_reset();
        cycle(1'b1, 1'b1, 4'h0, mode_val(1'b1, 1'b1, 20'd2), "R11");
        for (int k = 0; k < 60; k++) cycle(1'b1, 1'b0, 4'hC, '0, "R11");
        cycle(1'b1, 1'b1, 4'h4, 32'hFFFF_FFFF, "R11");
        cycle(1'b1, 1'b1, 4'h8, 32'hFFFF_FFFF, "R11");
        cycle(1'b1, 1'b1, 4'hC, 32'hFFFF_FFFF, "R11");
        cycle(1'b1, 1'b0, 4'h0, '0, "R11");
        cycle(1'b1, 1'b0, 4'h4, '0, "R11");
        cycle(1'b1, 1'b0, 4'hC, '0, "R11");

        // R3: limit lowered below the running count
        do_reset();
        cycle(1'b1, 1'b1, 4'h0, mode_val(1'b1, 1'b1, 20'd9), "R3");
        for (int k = 0; k < 16 * 7 + 3; k++) cycle(1'b1, 1'b0, 4'hC, '0, "R3");
        cycle(1'b1, 1'b1, 4'h0, mode_val(1'b1, 1'b1, 20'd2), "R3");
        for (int k = 0; k < 100; k++) cycle(1'b1, 1'b0, 4'hC, '0, "R3");

        // R5: saturation of the tally
        do_reset();
        cycle(1'b1, 1'b1, 4'h0, mode_val(1'b0, 1'b1, 20'd0), "R5");
        for (int k = 0; k < 4100 * 16; k++) cycle(1'b0, 1'b0, 4'h0, '0, "R5");
        cycle(1'b1, 1'b0, 4'hC, '0, "R5 saturated");
        cycle(1'b1, 1'b0, 4'h8, '0, "R5 saturated");
        cycle(1'b1, 1'b0, 4'hC, '0, "R5 after ack");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule